// File: doc/BRIEF.md
# Indirect Masked Memory Access Port

The block is a port into a small memory of 64-bit entries. Each entry also holds a validity bit. A 32-bit data bus moves one half of an entry per command, and a half-select input picks that half. The location comes from an internal address register. After each access this register steps up or steps down, as the opcode of the instruction word selects. It wraps modulo the memory depth.

Writes can be restricted by one of seven mask registers. The mask field of the instruction picks the register. Mask code 0 turns masking off. A bit is written only where the chosen mask holds a 0 in the same half.

A separate strobe loads the mask registers, one half per load. A separate load input sets the address register. Read data and the stored validity bit appear one cycle after the read command and stay on the outputs until the next read.

Top module: `mem_access_port`

## Requirements
- R1: After reset, `rdata_o`, `rvalid_o` and the address are 0. `vbit_no` is 1. Every entry reads as data 0 with validity 1 (empty). Every mask register is 0.
- R2: `half_hi_i`=0 maps the bus to entry bits 31:0. `half_hi_i`=1 maps it to bits 63:32.
- R3: A command is a `cmd_valid_i` cycle with a legal opcode. With `we_ni`=0 it writes. With `we_ni`=1 it reads. Read data is on `rdata_o` in the cycle after the command, and `rvalid_o` is 1 for exactly that cycle.
- R4: A write stores `vbit_ni` as the entry's validity bit (0 = valid, 1 = empty). A read drives the stored bit on `vbit_no` together with the data.
- R5: Mask code `instr_i[8:6]`=000 writes every bit of the selected half.
- R6: With mask code k (1 to 7), a write updates only the bits whose bit in mask register k, same half, is 0. All other bits keep their old value.
- R7: Opcode `instr_i[5:0]`=6'b100110 accesses the location and then increments the address. Opcode 6'b100111 accesses it and then decrements the address. The address wraps from DEPTH-1 to 0 and from 0 to DEPTH-1.
- R8: A `cmd_valid_i` cycle with any other opcode changes no entry, does not change the address and does not raise `rvalid_o`.
- R9: `mask_we_i` with `mask_sel_i` k (1 to 7) loads `mask_data_i` into half `mask_half_i` (0 = bits 31:0) of mask register k. With `mask_sel_i`=0 the load has no effect, and code 000 stays unmasked.
- R10: `addr_ld_i` loads `addr_ld_val_i` as the next address. It takes precedence over the step of a command in the same cycle. That command accesses the old address.
- R11: `rdata_o` and `vbit_no` hold their value until the next read command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Instruction strobe |
| instr_i | input | INSTR_W | Instruction word: bits 5:0 opcode, bits 8:6 mask code |
| we_ni | input | 1 | 0 = write, 1 = read |
| half_hi_i | input | 1 | Half select: 0 = bits 31:0, 1 = bits 63:32 |
| wdata_i | input | BUS_W | Write data |
| vbit_ni | input | 1 | Validity to store on a write (0 = valid) |
| mask_we_i | input | 1 | Mask register load strobe |
| mask_sel_i | input | 3 | Mask register index |
| mask_half_i | input | 1 | Mask half to load |
| mask_data_i | input | BUS_W | Mask load data |
| addr_ld_i | input | 1 | Address register load |
| addr_ld_val_i | input | AW | Address load value |
| rdata_o | output | BUS_W | Read data |
| vbit_no | output | 1 | Stored validity of the last read |
| rvalid_o | output | 1 | Read data valid pulse |

## Verification
The hardest case to reach from the ports is an address load and a command in the same cycle. The bench must show that the access lands on the old address while the step is dropped. It reaches this by first placing a known value at both addresses. It then issues the load together with a write. Separate reads at the loaded address and at the old one show where the write landed. The wrap cases are reached by loading the address to either end and stepping past it. The mask-code-0 case is reached by attempting to load register 0 with all ones before a write.

// File: rtl/map_pkg.sv
package map_pkg;
  localparam logic [5:0] OPC_INC = 6'b100110;
  localparam logic [5:0] OPC_DEC = 6'b100111;
  typedef enum logic [1:0] {STEP_NONE = 2'd0, STEP_UP = 2'd1, STEP_DN = 2'd2} step_e;
endpackage

// File: rtl/map_decode.sv
module map_decode
  import map_pkg::*;
#(
  parameter int INSTR_W = 12
) (
  input  logic               cmd_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               we_ni,
  output logic               wr_o,
  output logic               rd_o,
  output step_e              step_o,
  output logic [2:0]         mask_code_o
);
  logic is_inc, is_dec, legal;

  always_comb begin
    is_inc      = instr_i[5:0] == OPC_INC;
    is_dec      = instr_i[5:0] == OPC_DEC;
    legal       = cmd_valid_i && (is_inc || is_dec);
    wr_o        = legal && !we_ni;
    rd_o        = legal && we_ni;
    mask_code_o = instr_i[8:6];
    if (!legal)      step_o = STEP_NONE;
    else if (is_inc) step_o = STEP_UP;
    else             step_o = STEP_DN;
  end
endmodule

// File: rtl/map_addr_reg.sv
module map_addr_reg
  import map_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  step_e         step_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ld_i) addr_d = ld_val_i;
    else if (step_i == STEP_UP) addr_d = (addr_q == TOP) ? '0 : addr_q + 1'b1;
    else if (step_i == STEP_DN) addr_d = (addr_q == '0) ? TOP : addr_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;

  assign addr_o = addr_q;
endmodule

// File: rtl/map_mask_bank.sv
module map_mask_bank #(
  parameter int NUM_MASK = 8,
  parameter int BUS_W    = 32,
  localparam int ENTRY_W = 2 * BUS_W,
  localparam int SW      = $clog2(NUM_MASK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [SW-1:0]    ld_sel_i,
  input  logic             ld_half_i,
  input  logic [BUS_W-1:0] ld_data_i,
  input  logic [SW-1:0]    code_i,
  input  logic             half_i,
  output logic [BUS_W-1:0] mask_o
);
  logic [ENTRY_W-1:0] mask_q [NUM_MASK];

  // code 0 is the unmasked slot: tied to zero, never loaded
  assign mask_q[0] = '0;

  for (genvar i = 1; i < NUM_MASK; i++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) mask_q[i] <= '0;
      else if (ld_i && ld_sel_i == SW'(i)) begin
        if (ld_half_i) mask_q[i][ENTRY_W-1:BUS_W] <= ld_data_i;
        else           mask_q[i][BUS_W-1:0]       <= ld_data_i;
      end
  end

  always_comb begin
    logic [ENTRY_W-1:0] sel;
    sel    = mask_q[code_i];
    mask_o = half_i ? sel[ENTRY_W-1:BUS_W] : sel[BUS_W-1:0];
  end
endmodule

// File: rtl/map_entry_store.sv
module map_entry_store #(
  parameter int DEPTH = 16,
  parameter int BUS_W = 32,
  localparam int ENTRY_W = 2 * BUS_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             half_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] wmask_i,
  input  logic             vbit_ni,
  output logic [BUS_W-1:0] rdata_o,
  output logic             vbit_no,
  output logic             rvalid_o
);
  logic [ENTRY_W-1:0] mem_q  [DEPTH];
  logic               vb_n_q [DEPTH];
  logic [BUS_W-1:0]   old_half, new_half;

  always_comb begin
    old_half = half_i ? mem_q[addr_i][ENTRY_W-1:BUS_W] : mem_q[addr_i][BUS_W-1:0];
    // mask bit 1 protects the stored bit
    new_half = (old_half & wmask_i) | (wdata_i & ~wmask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i]  <= '0;
        vb_n_q[i] <= 1'b1;
      end
    end else if (wr_i) begin
      if (half_i) mem_q[addr_i][ENTRY_W-1:BUS_W] <= new_half;
      else        mem_q[addr_i][BUS_W-1:0]       <= new_half;
      vb_n_q[addr_i] <= vbit_ni;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_o  <= '0;
      vbit_no  <= 1'b1;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) begin
        rdata_o <= old_half;
        vbit_no <= vb_n_q[addr_i];
      end
    end
endmodule

// File: rtl/mem_access_port.sv
module mem_access_port
  import map_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BUS_W    = 32,
  parameter int INSTR_W  = 12,
  parameter int NUM_MASK = 8,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               we_ni,
  input  logic               half_hi_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               vbit_ni,
  input  logic               mask_we_i,
  input  logic [2:0]         mask_sel_i,
  input  logic               mask_half_i,
  input  logic [BUS_W-1:0]   mask_data_i,
  input  logic               addr_ld_i,
  input  logic [AW-1:0]      addr_ld_val_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               vbit_no,
  output logic               rvalid_o
);
  logic          wr, rd;
  step_e         step;
  logic [2:0]    mask_code;
  logic [AW-1:0] addr_q;
  logic [BUS_W-1:0] wmask;

  map_decode #(.INSTR_W(INSTR_W)) u_dec (
    .cmd_valid_i(cmd_valid_i), .instr_i(instr_i), .we_ni(we_ni),
    .wr_o(wr), .rd_o(rd), .step_o(step), .mask_code_o(mask_code)
  );

  map_addr_reg #(.DEPTH(DEPTH)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(addr_ld_i), .ld_val_i(addr_ld_val_i),
    .step_i(step), .addr_o(addr_q)
  );

  map_mask_bank #(.NUM_MASK(NUM_MASK), .BUS_W(BUS_W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(mask_we_i), .ld_sel_i(mask_sel_i),
    .ld_half_i(mask_half_i), .ld_data_i(mask_data_i), .code_i(mask_code),
    .half_i(half_hi_i), .mask_o(wmask)
  );

  map_entry_store #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .addr_i(addr_q),
    .half_i(half_hi_i), .wdata_i(wdata_i), .wmask_i(wmask), .vbit_ni(vbit_ni),
    .rdata_o(rdata_o), .vbit_no(vbit_no), .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/map_chk.sv
module map_chk
  import map_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int INSTR_W = 12,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               we_ni,
  input logic               addr_ld_i,
  input logic [AW-1:0]      addr_ld_val_i,
  input logic               rvalid_o,
  input logic [AW-1:0]      addr_q
);
  logic c_inc, c_dec;
  assign c_inc = cmd_valid_i && instr_i[5:0] == OPC_INC;
  assign c_dec = cmd_valid_i && instr_i[5:0] == OPC_DEC;

  function automatic logic [AW-1:0] nxt_up(logic [AW-1:0] a);
    return (int'(a) == DEPTH - 1) ? '0 : a + 1'b1;
  endfunction
  function automatic logic [AW-1:0] nxt_dn(logic [AW-1:0] a);
    return (a == '0) ? AW'(DEPTH - 1) : a - 1'b1;
  endfunction

  p_rd_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((c_inc || c_dec) && we_ni) |=> rvalid_o);
  p_no_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((c_inc || c_dec) && we_ni) |=> !rvalid_o);
  p_step_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_inc && !addr_ld_i) |=> addr_q == nxt_up($past(addr_q)));
  p_step_dn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_dec && !addr_ld_i) |=> addr_q == nxt_dn($past(addr_q)));
  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c_inc && !c_dec && !addr_ld_i) |=> $stable(addr_q));
  p_addr_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ld_i |=> addr_q == $past(addr_ld_val_i));
endmodule

bind mem_access_port map_chk #(.DEPTH(DEPTH), .INSTR_W(INSTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .instr_i(instr_i),
  .we_ni(we_ni), .addr_ld_i(addr_ld_i), .addr_ld_val_i(addr_ld_val_i),
  .rvalid_o(rvalid_o), .addr_q(addr_q)
);

// File: tb/sim_mem_access_port.sv
module sim_mem_access_port;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam logic [5:0] INC = 6'b100110, DEC = 6'b100111;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, we_n = 1, half_hi = 0, vbit_n = 1;
  logic [11:0] instr = '0;
  logic [31:0] wdata = '0, mask_data = '0, rdata;
  logic mask_we = 0, mask_half = 0, addr_ld = 0, vbit_out, rvalid;
  logic [2:0] mask_sel = '0;
  logic [AW-1:0] addr_ld_val = '0;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_data [DEPTH];
  logic        m_vb   [DEPTH];
  logic [63:0] m_mask [8];
  logic [AW-1:0] m_addr;
  logic [31:0] e_rd;
  logic        e_vb;

  always #5 clk = ~clk;

  mem_access_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .instr_i(instr),
    .we_ni(we_n), .half_hi_i(half_hi), .wdata_i(wdata), .vbit_ni(vbit_n),
    .mask_we_i(mask_we), .mask_sel_i(mask_sel), .mask_half_i(mask_half),
    .mask_data_i(mask_data), .addr_ld_i(addr_ld), .addr_ld_val_i(addr_ld_val),
    .rdata_o(rdata), .vbit_no(vbit_out), .rvalid_o(rvalid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: optional command and/or address load; model updated, outputs checked
  task automatic cyc(input bit cmd, input bit wn, input bit hi, input logic [31:0] wd,
                     input bit vbn, input logic [2:0] mc, input logic [5:0] op,
                     input bit ld, input logic [AW-1:0] ldv, input string req);
    bit legal;
    logic [31:0] oldh, m;
    @(negedge clk);
    cmd_valid = cmd; we_n = wn; half_hi = hi; wdata = wd; vbit_n = vbn;
    instr = {3'b000, mc, op}; addr_ld = ld; addr_ld_val = ldv;
    legal = cmd && (op == INC || op == DEC);
    oldh = hi ? m_data[m_addr][63:32] : m_data[m_addr][31:0];
    m    = hi ? m_mask[mc][63:32] : m_mask[mc][31:0];
    if (legal && !wn) begin
      if (hi) m_data[m_addr][63:32] = (oldh & m) | (wd & ~m);
      else    m_data[m_addr][31:0]  = (oldh & m) | (wd & ~m);
      m_vb[m_addr] = vbn;
    end
    if (legal && wn) begin e_rd = oldh; e_vb = m_vb[m_addr]; end
    if (ld) m_addr = ldv;
    else if (legal) m_addr = (op == INC) ? m_addr + 1'b1 : m_addr - 1'b1;
    @(negedge clk);
    cmd_valid = 0; addr_ld = 0;
    chk(rvalid == (legal && wn), req, {63'b0, rvalid}, {63'b0, legal && wn});
    chk(rdata == e_rd && vbit_out == e_vb, req, {31'b0, vbit_out, rdata}, {31'b0, e_vb, e_rd});
  endtask

  task automatic ld_addr(input logic [AW-1:0] a);
    cyc(0, 1, 0, 0, 1, 0, 0, 1, a, "R10");
  endtask
  task automatic wr(input bit hi, input logic [31:0] d, input bit vbn, input logic [2:0] mc,
                    input logic [5:0] op, input string req);
    cyc(1, 0, hi, d, vbn, mc, op, 0, 0, req);
  endtask
  task automatic rd(input bit hi, input logic [5:0] op, input string req);
    cyc(1, 1, hi, 0, 1, 0, op, 0, 0, req);
  endtask
  task automatic ld_mask(input logic [2:0] k, input bit hi, input logic [31:0] d);
    @(negedge clk);
    mask_we = 1; mask_sel = k; mask_half = hi; mask_data = d;
    if (k != 0) begin
      if (hi) m_mask[k][63:32] = d; else m_mask[k][31:0] = d;
    end
    @(negedge clk);
    mask_we = 0;
  endtask

  task automatic t_reset;
    chk(rvalid == 0 && rdata == 0 && vbit_out == 1, "R1", {31'b0, vbit_out, rdata}, 64'h1_0000_0000);
    rd(0, INC, "R1"); rd(1, INC, "R1");
  endtask

  task automatic t_halves;
    ld_addr(0);
    for (int i = 0; i < 4; i++) wr(0, 32'h1100_0000 + i, 0, 0, INC, "R2");
    ld_addr(0);
    for (int i = 0; i < 4; i++) wr(1, 32'hA5A5_0000 + i, 0, 0, INC, "R5");
    ld_addr(0);
    for (int i = 0; i < 4; i++) begin rd(0, INC, "R2"); end
    ld_addr(0);
    for (int i = 0; i < 4; i++) begin rd(1, INC, "R3"); end
  endtask

  task automatic t_validity;
    ld_addr(5); wr(0, 32'h55, 0, 0, INC, "R4");
    ld_addr(5); rd(0, INC, "R4");
    ld_addr(5); wr(1, 32'h66, 1, 0, INC, "R4");
    ld_addr(5); rd(1, INC, "R4"); rd(0, INC, "R4");
  endtask

  task automatic t_wrap;
    ld_addr(15); wr(0, 32'hF00D_000F, 0, 0, INC, "R7");
    wr(0, 32'h0000_BEEF, 0, 0, DEC, "R7");
    wr(0, 32'h1234_5678, 0, 0, INC, "R7");
    ld_addr(0); rd(0, DEC, "R7"); rd(0, DEC, "R7"); rd(0, DEC, "R7");
  endtask

  task automatic t_mask;
    ld_mask(3, 0, 32'hFFFF_0000);
    ld_mask(3, 1, 32'h0000_FFFF);
    ld_addr(7); wr(0, 32'h0, 0, 0, INC, "R6");
    ld_addr(7); wr(1, 32'h0, 0, 0, INC, "R6");
    ld_addr(7); wr(0, 32'hFFFF_FFFF, 0, 3, INC, "R6");
    ld_addr(7); wr(1, 32'hFFFF_FFFF, 0, 3, DEC, "R6");
    ld_addr(7); rd(0, INC, "R6");
    ld_addr(7); rd(1, INC, "R6");
    ld_mask(0, 0, 32'hFFFF_FFFF);
    ld_mask(0, 1, 32'hFFFF_FFFF);
    ld_addr(8); wr(0, 32'hCAFE_F00D, 0, 0, INC, "R9");
    ld_addr(8); rd(0, INC, "R9");
  endtask

  task automatic t_illegal;
    ld_addr(2);
    cyc(1, 0, 0, 32'hDEAD_DEAD, 0, 0, 6'b000010, 0, 0, "R8");
    cyc(1, 1, 0, 0, 1, 0, 6'b100101, 0, 0, "R8");
    rd(0, INC, "R8");
  endtask

  task automatic t_ld_prio;
    ld_addr(9); wr(0, 32'h0909_0909, 0, 0, INC, "R10");
    ld_addr(2);
    cyc(1, 0, 0, 32'h2222_2222, 0, 0, INC, 1, 9, "R10");
    rd(0, INC, "R10");
    ld_addr(2); rd(0, DEC, "R10");
  endtask

  task automatic t_hold;
    ld_addr(1); rd(1, INC, "R11");
    cyc(0, 1, 0, 0, 1, 0, 0, 0, 0, "R11");
    wr(1, 32'h7777_7777, 1, 0, INC, "R11");
    cyc(0, 1, 0, 0, 1, 0, 0, 0, 0, "R11");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_vb[i] = 1; end
    for (int i = 0; i < 8; i++) m_mask[i] = '0;
    m_addr = '0; e_rd = '0; e_vb = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_halves; t_validity; t_wrap; t_mask; t_illegal; t_ld_prio; t_hold;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule